// File: doc/BRIEF.md
# Transpose-Free Banked Weight Store

This block holds the weight matrices of every layer of a small multi-layer network in a square grid of P×P independent single-port-read, single-port-write memory banks. Each layer matrix of R rows and C columns is cut into a P×P grid of equal sub-blocks of R/P rows by C/P columns; sub-block (i, j) lives in bank (i, j). The matrices of later layers sit above those of earlier layers inside the same banks, so one grid serves the whole network.

A compute array asks for P weights per cycle. In row order (forward pass) it names a layer, a row r and a sub-offset k, and receives the P weights W[r][j·C/P + k] for j = 0..P-1. In column order (backward pass) it names a column c and a sub-offset k, and receives W[i·R/P + k][c] for i = 0..P-1. Because the P requested words always fall in P different banks, either order runs at one read per cycle with no transpose copy and no stall, and the two orders may be mixed freely cycle to cycle. A write port stores P words of one row per cycle in the row-order lane mapping, for weight writeback.

Top module: `wbs_top`

## Requirements
- R1: While reset is held, `rd_valid` is 0.
- R2: `rd_valid` is 1 in exactly the cycle after a cycle with `rd_en` = 1, and 0 otherwise; requests are accepted every cycle.
- R3: A row-order read (`rd_dir` = 0) of layer l, row r, sub-offset k returns in lane j (bits j·DW upward) the weight at row r, column j·(C/P) + k of that layer, one cycle later.
- R4: A column-order read (`rd_dir` = 1) of layer l, column c, sub-offset k returns in lane i the weight at row i·(R/P) + k, column c of that layer, one cycle later.
- R5: A write of layer l, row r, sub-offset k stores lane j of `wr_data` at row r, column j·(C/P) + k, visible to both read orders.
- R6: Writing any location of one layer leaves every weight of every other layer unchanged.
- R7: While `rd_en` is 0, `rd_data` keeps the value of the last completed read.
- R8: A read and a write to the same location in the same cycle return the value held before the write; a later read returns the written value.
- R9: Row-order and column-order reads may alternate on consecutive cycles, each returning correct data with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request this cycle |
| rd_dir | input | 1 | 0 row order, 1 column order |
| rd_layer | input | LW | Layer to read |
| rd_idx | input | IW | Row (row order) or column (column order) |
| rd_sub | input | IW | Sub-offset k inside each sub-block |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | P·DW | P weights, lane n at bits n·DW |
| wr_en | input | 1 | Write request this cycle |
| wr_layer | input | LW | Layer to write |
| wr_row | input | IW | Row to write |
| wr_sub | input | IW | Sub-offset k of the written words |
| wr_data | input | P·DW | P weights, lane j at bits j·DW |

## Verification
The hardest situation to reach is the one where the two orders meet: a word written through the row-order lane mapping must reappear in the right lane of a column-order read of a layer whose sub-block shape differs from its neighbours. The stimulus fills every layer through the write port with values that encode layer, row and column, then sweeps every row and every column of every layer and alternates the two orders on consecutive cycles. It then rewrites one layer with a different pattern and sweeps the others, and finishes with a read and a write colliding on one address in one cycle.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

   typedef enum logic {
      ORDER_ROW = 1'b0,
      ORDER_COL = 1'b1
   } order_e;

   // width of an index able to name n items, never below one bit
   function automatic int idx_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/wbs_addr_gen.sv
// Turns (layer, order, index, sub-offset) into the selected bank line of the
// grid and the word address inside every bank taking part.
module wbs_addr_gen #(
   parameter int P            = 4,
   parameter int NL           = 3,
   parameter int DIMS [NL+1]  = '{8, 16, 8, 4},
   parameter int LW           = 2,
   parameter int IW           = 4,
   parameter int SLW          = 2,
   parameter int AW           = 5
) (
   input  logic [LW-1:0]  layer,
   input  logic           col_order,
   input  logic [IW-1:0]  idx,
   input  logic [IW-1:0]  sub,
   output logic [SLW-1:0] sel,
   output logic [AW-1:0]  addr
);

   function automatic int layer_base(input int upto);
      int acc;
      acc = 0;
      for (int k = 0; k < upto; k++) begin
         acc += (DIMS[k] / P) * (DIMS[k+1] / P);
      end
      return acc;
   endfunction

   logic [31:0] ix;
   logic [31:0] sx;
   assign ix = 32'(idx);
   assign sx = 32'(sub);

   logic [SLW-1:0] cand_sel  [NL];
   logic [AW-1:0]  cand_addr [NL];

   for (genvar l = 0; l < NL; l++) begin : g_layer
      localparam logic [31:0] RB = 32'(DIMS[l] / P);
      localparam logic [31:0] CB = 32'(DIMS[l+1] / P);
      localparam logic [31:0] BS = 32'(layer_base(l));

      logic [31:0] row_addr;
      logic [31:0] col_addr;
      logic [31:0] row_line;
      logic [31:0] col_line;

      // row order: grid row = r / RB, word = (r mod RB) * CB + k
      assign row_line = ix / RB;
      assign row_addr = BS + (ix % RB) * CB + sx;
      // column order: grid column = c / CB, word = k * CB + (c mod CB)
      assign col_line = ix / CB;
      assign col_addr = BS + sx * CB + (ix % CB);

      assign cand_sel[l]  = col_order ? SLW'(col_line) : SLW'(row_line);
      assign cand_addr[l] = col_order ? AW'(col_addr)  : AW'(row_addr);
   end

   always_comb begin
      sel  = '0;
      addr = '0;
      for (int l = 0; l < NL; l++) begin
         if (layer == LW'(l)) begin
            sel  = cand_sel[l];
            addr = cand_addr[l];
         end
      end
   end

endmodule

// File: rtl/wbs_bank.sv
// One bank of the grid: one write and one registered read per cycle.
// A read and a write to the same word in one cycle return the old word.
module wbs_bank #(
   parameter int DW    = 16,
   parameter int DEPTH = 18,
   parameter int AW    = 5
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (re) begin
         rdata <= mem[raddr];
      end
   end

endmodule

// File: rtl/wbs_lane_sel.sv
// Remembers which grid line a read used and in which order, then steers the
// P participating bank outputs onto the output lanes.
module wbs_lane_sel #(
   parameter int P   = 4,
   parameter int DW  = 16,
   parameter int SLW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_en,
   input  logic            col_order,
   input  logic [SLW-1:0]  sel,
   input  logic [DW-1:0]   bank_q [P*P],
   output logic            valid,
   output logic [P*DW-1:0] data
);

   import wbs_pkg::*;

   localparam int BW = idx_w(P * P);

   order_e         order_q;
   logic [SLW-1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid   <= 1'b0;
         order_q <= ORDER_ROW;
         sel_q   <= '0;
      end else begin
         valid <= rd_en;
         if (rd_en) begin
            order_q <= col_order ? ORDER_COL : ORDER_ROW;
            sel_q   <= sel;
         end
      end
   end

   always_comb begin
      data = '0;
      for (int n = 0; n < P; n++) begin
         if (order_q == ORDER_COL) begin
            // lane n comes from grid row n, fixed grid column
            data[n*DW +: DW] = bank_q[BW'(n * P) + BW'(sel_q)];
         end else begin
            // lane n comes from fixed grid row, grid column n
            data[n*DW +: DW] = bank_q[BW'(sel_q) * BW'(P) + BW'(n)];
         end
      end
   end

endmodule

// File: rtl/wbs_top.sv
module wbs_top #(
   parameter int P           = 4,
   parameter int DW          = 16,
   parameter int NL          = 3,
   parameter int DIMS [NL+1] = '{8, 16, 8, 4},
   parameter int LW          = wbs_pkg::idx_w(NL),
   parameter int IW          = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_en,
   input  logic            rd_dir,
   input  logic [LW-1:0]   rd_layer,
   input  logic [IW-1:0]   rd_idx,
   input  logic [IW-1:0]   rd_sub,
   output logic            rd_valid,
   output logic [P*DW-1:0] rd_data,
   input  logic            wr_en,
   input  logic [LW-1:0]   wr_layer,
   input  logic [IW-1:0]   wr_row,
   input  logic [IW-1:0]   wr_sub,
   input  logic [P*DW-1:0] wr_data
);

   import wbs_pkg::*;

   function automatic int words_per_bank();
      int acc;
      acc = 0;
      for (int k = 0; k < NL; k++) begin
         acc += (DIMS[k] / P) * (DIMS[k+1] / P);
      end
      return acc;
   endfunction

   function automatic int widest_dim();
      int m;
      m = 1;
      for (int k = 0; k <= NL; k++) begin
         if (DIMS[k] > m) m = DIMS[k];
      end
      return m;
   endfunction

   localparam int DEPTH = words_per_bank();
   localparam int AW    = idx_w(DEPTH);
   localparam int SLW   = idx_w(P);

   // elaboration-time parameter checks
   if (P < 1) begin : g_bad_p
      $error("wbs_top: P must be at least 1");
   end
   if (NL < 1) begin : g_bad_nl
      $error("wbs_top: at least one layer is required");
   end
   if ((1 << IW) < widest_dim()) begin : g_bad_iw
      $error("wbs_top: IW too narrow for the widest layer dimension");
   end
   for (genvar l = 0; l <= NL; l++) begin : g_dim_chk
      if ((DIMS[l] < P) || (DIMS[l] % P != 0)) begin : g_bad_dim
         $error("wbs_top: every layer dimension must be a multiple of P");
      end
   end

   logic [SLW-1:0] rsel;
   logic [AW-1:0]  raddr;
   logic [SLW-1:0] wsel;
   logic [AW-1:0]  waddr;

   wbs_addr_gen #(
      .P(P), .NL(NL), .DIMS(DIMS), .LW(LW), .IW(IW), .SLW(SLW), .AW(AW)
   ) u_rd_addr (
      .layer     (rd_layer),
      .col_order (rd_dir),
      .idx       (rd_idx),
      .sub       (rd_sub),
      .sel       (rsel),
      .addr      (raddr)
   );

   // writes always use the row-order lane mapping
   wbs_addr_gen #(
      .P(P), .NL(NL), .DIMS(DIMS), .LW(LW), .IW(IW), .SLW(SLW), .AW(AW)
   ) u_wr_addr (
      .layer     (wr_layer),
      .col_order (1'b0),
      .idx       (wr_row),
      .sub       (wr_sub),
      .sel       (wsel),
      .addr      (waddr)
   );

   logic [DW-1:0] bank_q [P*P];

   for (genvar i = 0; i < P; i++) begin : g_grow
      for (genvar j = 0; j < P; j++) begin : g_gcol
         logic bre;
         logic bwe;

         assign bre = rd_en && (rd_dir ? (rsel == SLW'(j)) : (rsel == SLW'(i)));
         assign bwe = wr_en && (wsel == SLW'(i));

         wbs_bank #(
            .DW(DW), .DEPTH(DEPTH), .AW(AW)
         ) u_bank (
            .clk   (clk),
            .we    (bwe),
            .waddr (waddr),
            .wdata (wr_data[j*DW +: DW]),
            .re    (bre),
            .raddr (raddr),
            .rdata (bank_q[i*P + j])
         );
      end
   end

   wbs_lane_sel #(
      .P(P), .DW(DW), .SLW(SLW)
   ) u_lanes (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .col_order (rd_dir),
      .sel       (rsel),
      .bank_q    (bank_q),
      .valid     (rd_valid),
      .data      (rd_data)
   );

endmodule

// File: rtl/wbs_chk.sv
module wbs_chk #(
   parameter int P  = 4,
   parameter int DW = 16,
   parameter int LW = 2,
   parameter int IW = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rd_en,
   input logic            rd_dir,
   input logic [LW-1:0]   rd_layer,
   input logic [IW-1:0]   rd_idx,
   input logic [IW-1:0]   rd_sub,
   input logic            rd_valid,
   input logic [P*DW-1:0] rd_data,
   input logic            wr_en,
   input logic [LW-1:0]   wr_layer,
   input logic [IW-1:0]   wr_row,
   input logic [IW-1:0]   wr_sub,
   input logic [P*DW-1:0] wr_data
);

   a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   // R5 and R3: a row written, then read back in row order on the next cycle
   a_r5_row_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en ##1 (rd_en && !rd_dir && !wr_en
                  && rd_layer == $past(wr_layer)
                  && rd_idx   == $past(wr_row)
                  && rd_sub   == $past(wr_sub)))
      |=> (rd_data == $past(wr_data, 2)));

endmodule

bind wbs_top wbs_chk #(.P(P), .DW(DW), .LW(LW), .IW(IW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .rd_dir   (rd_dir),
   .rd_layer (rd_layer),
   .rd_idx   (rd_idx),
   .rd_sub   (rd_sub),
   .rd_valid (rd_valid),
   .rd_data  (rd_data),
   .wr_en    (wr_en),
   .wr_layer (wr_layer),
   .wr_row   (wr_row),
   .wr_sub   (wr_sub),
   .wr_data  (wr_data)
);

// File: tb/sim_wbs_top.sv
module sim_wbs_top;

   localparam int CLK_PERIOD = 10;
   localparam int P  = 4;
   localparam int DW = 16;
   localparam int NL = 3;
   localparam int DIMS [NL+1] = '{8, 16, 8, 4};
   localparam int LW = 2;
   localparam int IW = 4;
   localparam int MAXD = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            rd_en = 1'b0;
   logic            rd_dir = 1'b0;
   logic [LW-1:0]   rd_layer = '0;
   logic [IW-1:0]   rd_idx = '0;
   logic [IW-1:0]   rd_sub = '0;
   logic            rd_valid;
   logic [P*DW-1:0] rd_data;
   logic            wr_en = 1'b0;
   logic [LW-1:0]   wr_layer = '0;
   logic [IW-1:0]   wr_row = '0;
   logic [IW-1:0]   wr_sub = '0;
   logic [P*DW-1:0] wr_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wbs_top #(.P(P), .DW(DW), .NL(NL), .DIMS(DIMS), .LW(LW), .IW(IW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .rd_en(rd_en), .rd_dir(rd_dir), .rd_layer(rd_layer),
      .rd_idx(rd_idx), .rd_sub(rd_sub),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .wr_en(wr_en), .wr_layer(wr_layer), .wr_row(wr_row),
      .wr_sub(wr_sub), .wr_data(wr_data)
   );

   // reference model: plain matrices per layer
   logic [DW-1:0]   wm [NL][MAXD][MAXD];
   logic            exp_valid = 1'b0;
   logic [P*DW-1:0] exp_data = '0;
   logic            have_data = 1'b0;
   logic            run = 1'b0;
   logic            done = 1'b0;
   string           cur_req = "R3";
   int              n_cmp = 0;
   int              n_bad = 0;

   function automatic logic [DW-1:0] pat(input int l, input int r, input int c, input int salt);
      return DW'(l * 1024 + r * 32 + c + 1) ^ DW'(salt);
   endfunction

   // expected values follow the sampled requests at each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         exp_valid = 1'b0;
      end else begin
         exp_valid = rd_en;
         if (rd_en) begin
            int l;
            l = int'(rd_layer);
            for (int n = 0; n < P; n++) begin
               int r;
               int c;
               if (rd_dir) begin
                  c = int'(rd_idx);
                  r = n * (DIMS[l] / P) + int'(rd_sub);
               end else begin
                  r = int'(rd_idx);
                  c = n * (DIMS[l+1] / P) + int'(rd_sub);
               end
               exp_data[n*DW +: DW] = wm[l][r][c];
            end
            have_data = 1'b1;
         end
         if (wr_en) begin
            int l;
            l = int'(wr_layer);
            for (int n = 0; n < P; n++) begin
               wm[l][int'(wr_row)][n * (DIMS[l+1] / P) + int'(wr_sub)] = wr_data[n*DW +: DW];
            end
         end
      end
   end

   // compare on every clock, away from the rising edge
   always @(negedge clk) begin
      if (run && rst_n) begin
         n_cmp++;
         if (rd_valid !== exp_valid) begin
            n_bad++;
            $display("FAIL R2 rd_valid actual=%0b expected=%0b", rd_valid, exp_valid);
         end
         if (have_data) begin
            n_cmp++;
            if (rd_data !== exp_data) begin
               n_bad++;
               $display("FAIL %s rd_data actual=%h expected=%h", cur_req, rd_data, exp_data);
            end
         end
      end
   end

   task automatic cyc(input logic re, input logic dir, input int rl, input int ri, input int rs,
                      input logic we, input int wl, input int wr, input int ws,
                      input logic [P*DW-1:0] wd);
      rd_en    = re;
      rd_dir   = dir;
      rd_layer = LW'(rl);
      rd_idx   = IW'(ri);
      rd_sub   = IW'(rs);
      wr_en    = we;
      wr_layer = LW'(wl);
      wr_row   = IW'(wr);
      wr_sub   = IW'(ws);
      wr_data  = wd;
      @(negedge clk);
   endtask

   task automatic idle();
      cyc(1'b0, 1'b0, 0, 0, 0, 1'b0, 0, 0, 0, '0);
   endtask

   task automatic rd(input logic dir, input int l, input int i, input int s);
      cyc(1'b1, dir, l, i, s, 1'b0, 0, 0, 0, '0);
   endtask

   task automatic fill_layer(input int l, input int salt);
      for (int r = 0; r < DIMS[l]; r++) begin
         for (int k = 0; k < DIMS[l+1] / P; k++) begin
            logic [P*DW-1:0] d;
            for (int n = 0; n < P; n++) begin
               d[n*DW +: DW] = pat(l, r, n * (DIMS[l+1] / P) + k, salt);
            end
            cyc(1'b0, 1'b0, 0, 0, 0, 1'b1, l, r, k, d);
         end
      end
   endtask

   task automatic sweep_rows(input int l);
      for (int r = 0; r < DIMS[l]; r++) begin
         for (int k = 0; k < DIMS[l+1] / P; k++) rd(1'b0, l, r, k);
      end
   endtask

   task automatic sweep_cols(input int l);
      for (int c = 0; c < DIMS[l+1]; c++) begin
         for (int k = 0; k < DIMS[l] / P; k++) rd(1'b1, l, c, k);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset held, valid low
      n_cmp++;
      if (rd_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 rd_valid actual=%0b expected=0", rd_valid);
      end
      rst_n = 1'b1;
      run   = 1'b1;
      @(negedge clk);

      // R5: fill every layer through the write port
      cur_req = "R5";
      for (int l = 0; l < NL; l++) fill_layer(l, 0);
      idle();

      // R3: every row of every layer
      cur_req = "R3";
      for (int l = 0; l < NL; l++) sweep_rows(l);

      // R7: idle cycles keep the last read data
      cur_req = "R7";
      repeat (3) idle();

      // R4: every column of every layer
      cur_req = "R4";
      for (int l = 0; l < NL; l++) sweep_cols(l);

      // R9: row and column orders alternate each cycle, across layers
      cur_req = "R9";
      for (int t = 0; t < 24; t++) begin
         int l;
         l = t % NL;
         rd(1'b0, l, (t * 3) % DIMS[l], t % (DIMS[l+1] / P));
         rd(1'b1, l, (t * 5) % DIMS[l+1], t % (DIMS[l] / P));
      end
      idle();

      // R6: rewrite layer 1 with another pattern, neighbours must be intact
      cur_req = "R6";
      fill_layer(1, 16'hA5A5);
      sweep_cols(0);
      sweep_rows(2);
      sweep_cols(2);
      cur_req = "R4";
      sweep_cols(1);

      // R8: read and write of one location in one cycle
      cur_req = "R8";
      begin
         logic [P*DW-1:0] d;
         for (int n = 0; n < P; n++) d[n*DW +: DW] = DW'(16'h7000 + n);
         cyc(1'b1, 1'b0, 0, 3, 1, 1'b1, 0, 3, 1, d);
         rd(1'b0, 0, 3, 1);
         rd(1'b1, 0, 1 * (DIMS[1] / P) + 1, 3 % (DIMS[0] / P));
         idle();
      end

      repeat (2) idle();
      run  = 1'b0;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule